// File: doc/BRIEF.md
# Free-Running Timer with Input Capture

This block keeps a free-running up-counter that advances once every `DIV` system clocks, six by default. A host sees the count only through two capture registers, each read a byte at a time. A read of the low byte of the software capture register copies the whole count into that register. The later high-byte read then returns the upper half of that same snapshot, even though the counter has moved on.

The second register records the count when the serial tape input changes. A three-bit mode code chooses which change counts: falling, rising, either, or none. Each edge capture gives a one-cycle event pulse. Each counter wrap gives a one-cycle overflow pulse. Both pulses go to an external interrupt controller.

Top module: `frc_capture`

## Requirements
- R1: After reset the counter is 0. It advances by one every `DIV` clocks (default 6), so after n clock edges out of reset it holds floor(n/DIV) mod 2^CNT_W.
- R2: The counter wraps from all-ones to 0. `ovf_o` is high for exactly one cycle, the cycle in which the counter first reads 0 after the wrap.
- R3: With edge mode code 2, a 1-to-0 change of the synchronised tape input loads the count into the edge capture register and pulses `cap_evt_o`.
- R4: With edge mode code 4, a 0-to-1 change of the synchronised tape input captures and pulses `cap_evt_o`.
- R5: With edge mode code 6, any change of the synchronised tape input captures and pulses `cap_evt_o`.
- R6: With any other edge mode code (0, 1, 3, 5, 7), tape changes raise no event and leave the edge capture register unchanged.
- R7: Read select 0 returns bits 7:0 of the current count. When `rd_en_i` is high, it also latches the full count. Read select 1 returns bits 15:8 of the latched value, and later counting does not change it.
- R8: Read select 2 returns bits 7:0 of the edge capture register and select 3 returns bits 15:8. Selects 5 to 7 read 0. Reads of selects 1 to 7 change no state. Narrow values are zero-extended to 16 bits.
- R9: Read select 4 returns the synchronised tape level in bit 0 and zeros in bits 7:1. A change on `tape_i` appears there two clocks later.
- R10: An edge capture stores the count as it stood two clock edges after the tape change. `cap_evt_o` is high during the cycle after the third edge, for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tape_i | input | 1 | Asynchronous serial tape level |
| edge_mode_i | input | 3 | Capture edge code: 2 falling, 4 rising, 6 both, others off |
| rd_en_i | input | 1 | Read strobe; latches the count when select is 0 |
| rd_sel_i | input | 3 | Read byte select |
| rd_data_o | output | 8 | Selected read byte |
| ovf_o | output | 1 | One-cycle counter wrap pulse |
| cap_evt_o | output | 1 | One-cycle edge-capture pulse |

## Verification
The software latch and the edge capture can load in the same clock. A directed case provokes this by timing the host low-byte read so its latch edge is the same edge at which a synchronised tape change reaches capture. The case passes only if both registers hold the identical count, computed from the edge count since reset, and the event still pulses. Random reads are spread over a full counter wrap, so a latch or capture also lands next to the overflow pulse; the expected values there are the wrapped counts.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam logic [2:0] MODE_FALL = 3'd2;
  localparam logic [2:0] MODE_RISE = 3'd4;
  localparam logic [2:0] MODE_ANY  = 3'd6;

  localparam logic [2:0] SEL_SW_LO   = 3'd0;
  localparam logic [2:0] SEL_SW_HI   = 3'd1;
  localparam logic [2:0] SEL_EDGE_LO = 3'd2;
  localparam logic [2:0] SEL_EDGE_HI = 3'd3;
  localparam logic [2:0] SEL_STATUS  = 3'd4;

  localparam int unsigned HOST_W = 16;
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == PRE_LAST);

      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R1
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      wrap_q <= tick_i && (cnt_q == '1);
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (cnt_q == '0)); // R2
  AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o); // R2
endmodule

// File: rtl/frc_edge_capture.sv
module frc_edge_capture
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tape_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             level_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             evt_o
);
  logic [1:0]       sync_q;
  logic             prev_q;
  logic             rise, fall, hit;
  logic [CNT_W-1:0] cap_q;
  logic             evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tape_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise = sync_q[1] & ~prev_q;
  assign fall = ~sync_q[1] & prev_q;

  always_comb begin
    case (mode_i)
      MODE_FALL: hit = fall;
      MODE_RISE: hit = rise;
      MODE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= hit;
      if (hit) cap_q <= cnt_i;
    end
  end

  assign level_o = sync_q[1];
  assign cap_o   = cap_q;
  assign evt_o   = evt_q;

  AST_EVT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> ($past(mode_i) == MODE_FALL || $past(mode_i) == MODE_RISE ||
               $past(mode_i) == MODE_ANY)); // R6
  AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $past(mode_i) == MODE_FALL) |-> !prev_q); // R3
  AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $past(mode_i) == MODE_RISE) |-> prev_q); // R4
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |-> $stable(cap_q)); // R6
  AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R10
endmodule

// File: rtl/frc_capture.sv
module frc_capture
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV   = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tape_i,
  input  logic [2:0] edge_mode_i,
  input  logic       rd_en_i,
  input  logic [2:0] rd_sel_i,
  output logic [7:0] rd_data_o,
  output logic       ovf_o,
  output logic       cap_evt_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] edge_cap;
  logic             level;
  logic [CNT_W-1:0] sw_cap_q;
  logic             sw_latch;
  logic [HOST_W-1:0] cnt_w, sw_w, edge_w;

  frc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .cnt_o (cnt),
    .wrap_o(ovf_o)
  );

  frc_edge_capture #(.CNT_W(CNT_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tape_i (tape_i),
    .mode_i (edge_mode_i),
    .cnt_i  (cnt),
    .level_o(level),
    .cap_o  (edge_cap),
    .evt_o  (cap_evt_o)
  );

  assign sw_latch = rd_en_i && (rd_sel_i == SEL_SW_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_cap_q <= '0;
    else if (sw_latch) sw_cap_q <= cnt;
  end

  assign cnt_w  = HOST_W'(cnt);
  assign sw_w   = HOST_W'(sw_cap_q);
  assign edge_w = HOST_W'(edge_cap);

  always_comb begin
    case (rd_sel_i)
      SEL_SW_LO:   rd_data_o = cnt_w[7:0];
      SEL_SW_HI:   rd_data_o = sw_w[15:8];
      SEL_EDGE_LO: rd_data_o = edge_w[7:0];
      SEL_EDGE_HI: rd_data_o = edge_w[15:8];
      SEL_STATUS:  rd_data_o = {7'b0, level};
      default:     rd_data_o = 8'h00;
    endcase
  end

  AST_SW_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_latch |=> (sw_cap_q == $past(cnt))); // R7
  AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_latch |=> $stable(sw_cap_q)); // R8
endmodule

// File: tb/frc_capture_bench.sv
`timescale 1ns/1ps
module frc_capture_bench;
  localparam int unsigned W   = 10;
  localparam int unsigned DIV = 6;
  localparam int unsigned MOD = 1 << W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tape = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_sel = 3'd7;
  logic [7:0] rd_data;
  logic       ovf, evt;

  int unsigned n = 0;
  int tests = 0;
  int fails = 0;
  int unsigned exp_cap = 0;

  always #4 clk = ~clk;

  frc_capture #(.CNT_W(W), .DIV(DIV)) u_frc_capture (
    .clk_i(clk), .rst_ni(rst_n), .tape_i(tape), .edge_mode_i(mode),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .ovf_o(ovf), .cap_evt_o(evt)
  );

  always @(posedge clk) if (rst_n) n <= n + 1;

  function automatic int unsigned cnt_at(input int unsigned k);
    return (k / DIV) % MOD;
  endfunction

  function automatic bit mode_hit(input logic [2:0] m, input bit o, input bit v);
    case (m)
      3'd2: return o && !v;
      3'd4: return !o && v;
      3'd6: return o != v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at n=%0d", req, act, exp, n);
    end
  endtask

  // called at a negedge, returns one negedge later
  task automatic read_byte(input logic [2:0] sel, input bit latch, output logic [7:0] v);
    rd_sel = sel;
    rd_en  = latch;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // R2 overflow monitor
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit exp_ovf = (n != 0) && (n % DIV == 0) && ((n / DIV) % MOD == 0);
      if (exp_ovf || ovf) check("R2 ovf", ovf, exp_ovf);
    end
  end

  task automatic edge_case(input logic [2:0] m, input bit v, input string req);
    int unsigned k;
    bit o, h;
    logic [7:0] b;
    mode = m;
    repeat (4) @(negedge clk);
    o = tape;
    h = mode_hit(m, o, v);
    k = n;
    tape = v;
    repeat (3) @(negedge clk);
    check({req, " R10 evt"}, evt, h);
    if (h) exp_cap = cnt_at(k + 2);
    read_byte(3'd2, 1'b0, b);
    check({req, " R8 edge lo"}, b, exp_cap & 8'hFF);
    check({req, " R10 evt single"}, evt, 0);
    read_byte(3'd3, 1'b0, b);
    check({req, " R8 edge hi"}, b, (exp_cap >> 8) & 8'hFF);
  endtask

  task automatic sw_pair(input int unsigned gap);
    int unsigned k, snap;
    logic [7:0] b;
    k = n;
    snap = cnt_at(k);
    read_byte(3'd0, 1'b1, b);
    check("R7 sw lo", b, snap & 8'hFF);
    repeat (gap) @(negedge clk);
    read_byte(3'd1, 1'b0, b);
    check("R7 sw hi", b, (snap >> 8) & 8'hFF);
  endtask

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int unsigned k;
    void'($urandom(32'd2024));

    // reset state
    repeat (3) @(negedge clk);
    rd_sel = 3'd2; #1 check("R1 reset edge lo", rd_data, 0);
    rd_sel = 3'd0; #1 check("R1 reset count", rd_data, 0);
    check("R2 reset ovf", ovf, 0);
    check("R10 reset evt", evt, 0);
    rst_n = 1'b1;

    // R1 advance rate
    repeat (13) @(negedge clk);
    read_byte(3'd0, 1'b0, b);
    check("R1 count at n=13", b, cnt_at(13));

    // R9 status latency
    mode = 3'd0;
    repeat (3) @(negedge clk);
    tape = 1'b1;
    @(negedge clk); rd_sel = 3'd4; #1 check("R9 status one clk", rd_data, 0);
    @(negedge clk); rd_sel = 3'd4; #1 check("R9 status two clk", rd_data, 1);
    // R8 unused selects
    rd_sel = 3'd5; #1 check("R8 sel5", rd_data, 0);
    rd_sel = 3'd7; #1 check("R8 sel7", rd_data, 0);

    // directed edge modes
    edge_case(3'd2, 1'b0, "R3 fall");
    edge_case(3'd2, 1'b1, "R3 rise ignored");
    edge_case(3'd4, 1'b0, "R4 fall ignored");
    edge_case(3'd4, 1'b1, "R4 rise");
    edge_case(3'd6, 1'b0, "R5 fall");
    edge_case(3'd6, 1'b1, "R5 rise");
    edge_case(3'd0, 1'b0, "R6 mode0");
    edge_case(3'd7, 1'b1, "R6 mode7");
    edge_case(3'd3, 1'b0, "R6 mode3");
    edge_case(3'd5, 1'b1, "R6 mode5");

    // R7 coherent latch
    sw_pair(40);

    // concurrent software latch and edge capture
    mode = 3'd6;
    repeat (4) @(negedge clk);
    k = n;
    tape = ~tape;
    repeat (2) @(negedge clk);
    read_byte(3'd0, 1'b1, b);
    check("R7 concurrent sw lo", b, cnt_at(k + 2) & 8'hFF);
    check("R5 concurrent evt", evt, 1);
    exp_cap = cnt_at(k + 2);
    read_byte(3'd1, 1'b0, b);
    check("R7 concurrent sw hi", b, (exp_cap >> 8) & 8'hFF);
    read_byte(3'd2, 1'b0, b);
    check("R5 concurrent edge lo", b, exp_cap & 8'hFF);
    read_byte(3'd3, 1'b0, b);
    check("R5 concurrent edge hi", b, (exp_cap >> 8) & 8'hFF);

    // random mix
    for (int i = 0; i < 40; i++) begin
      edge_case(3'($urandom % 8), 1'($urandom % 2), "R6 random");
      repeat ($urandom % 50) @(negedge clk);
      sw_pair($urandom % 30);
    end

    // R2 directed wrap
    while (n < DIV * MOD - 1) @(negedge clk);
    read_byte(3'd0, 1'b1, b);
    check("R2 before wrap lo", b, (MOD - 1) & 8'hFF);
    read_byte(3'd0, 1'b0, b);
    check("R2 after wrap lo", b, 0);
    read_byte(3'd1, 1'b0, b);
    check("R7 hi keeps pre-wrap", b, ((MOD - 1) >> 8) & 8'hFF);

    // cover second wrap with more random traffic
    while (n < 2 * DIV * MOD + 20) begin
      sw_pair($urandom % 100);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule